// File: doc/BRIEF.md
# Bypassing Store Buffer

This block sits between one processor and the memory interconnect. It absorbs processor writes into a small first-in first-out queue and releases the processor in the same cycle. The queue drains toward memory in the background. A write leaves the queue only after memory acknowledges it, so the block always knows which writes are still pending.

Reads are not held behind the queue. A read whose address matches a queued write is answered from the buffer, using the youngest matching entry. The processor therefore sees its own earlier store before memory has taken it, and order between a read and a write to the same address is kept. A read that matches nothing becomes a memory read and takes priority over the queued writes at the next free memory slot. The memory port carries one transaction at a time. A read miss stalls the processor until the data returns.

Top module: `store_bypass_buf`

## Requirements
- R1: After reset, req_ready_o is 1, rsp_valid_o is 0, mem_req_valid_o is 0 and drained_o is 1.
- R2: A write is accepted in the cycle it is presented while fewer than DEPTH (default 4) entries are held. With DEPTH entries held, req_ready_o is 0 whenever req_write_i is 1.
- R3: Buffered writes reach memory (mem_req_write_o = 1) in the order they were accepted. The memory port has at most one transaction that memory has not yet acknowledged.
- R4: An entry is freed only when mem_ack_i acknowledges its write. drained_o is 1 exactly when no entry is held, and no memory write is presented while drained_o is 1.
- R5: A read miss is presented to memory (mem_req_write_o = 0) as soon as the port is free, ahead of any older buffered write.
- R6: A read hit returns the data of the youngest buffered write to that address, with rsp_valid_o high for one cycle in the cycle after acceptance, and with no memory read.
- R7: A read miss returns mem_rdata_i, with rsp_valid_o high in the cycle after the cycle in which mem_ack_i acknowledged that read.
- R8: From the acceptance of a read until its response, req_ready_o is 0.
- R9: Every read returns the value of the most recent write to that address, whether it is served from the buffer or from memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Processor request valid |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | AW | Request word address |
| req_wdata_i | input | DW | Write data |
| req_ready_o | output | 1 | Request accepted when high together with valid |
| rsp_valid_o | output | 1 | Read response valid, one-cycle pulse |
| rsp_rdata_o | output | DW | Read response data |
| mem_req_valid_o | output | 1 | Memory request valid |
| mem_req_write_o | output | 1 | 1 = write, 0 = read |
| mem_req_addr_o | output | AW | Memory request address |
| mem_req_wdata_o | output | DW | Memory write data |
| mem_req_ready_i | input | 1 | Memory accepts the request |
| mem_ack_i | input | 1 | Completion of the outstanding memory transaction |
| mem_rdata_i | input | DW | Read data, valid with mem_ack_i for a read |
| drained_o | output | 1 | No buffered or unacknowledged write |

## Verification
The hardest case to reach is a read miss that overtakes older writes. It needs a full queue, one write in flight and a read waiting for the port, all at once. The bench's memory model can withhold its acknowledgement indefinitely. With the acknowledgement withheld, the bench fills the queue and probes the full stall and a forwarded hit. It then issues a miss and releases the acknowledgement. The model logs the order of memory transactions, so the bench can confirm that the read came between the in-flight write and the queued ones, and that the writes still drained in order.

// File: rtl/sbuf_pkg.sv
package sbuf_pkg;
  typedef enum logic [1:0] {
    SEL_IDLE = 2'd0,
    SEL_WR   = 2'd1,
    SEL_RD   = 2'd2
  } mem_sel_e;
endpackage

// File: rtl/sbuf_fifo.sv
module sbuf_fifo #(
  parameter int AW    = 8,
  parameter int DW    = 32,
  parameter int DEPTH = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [AW-1:0] push_addr_i,
  input  logic [DW-1:0] push_data_i,
  input  logic          pop_i,
  input  logic [AW-1:0] look_addr_i,
  output logic          full_o,
  output logic          empty_o,
  output logic [AW-1:0] head_addr_o,
  output logic [DW-1:0] head_data_o,
  output logic          hit_o,
  output logic [DW-1:0] hit_data_o
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [AW-1:0] addr_q [DEPTH];
  logic [DW-1:0] data_q [DEPTH];
  logic [PW-1:0] wr_ptr_q, rd_ptr_q;
  logic [CW-1:0] cnt_q;

  function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
    return (int'(p) == DEPTH - 1) ? '0 : p + 1'b1;
  endfunction

  assign full_o      = (int'(cnt_q) == DEPTH);
  assign empty_o     = (cnt_q == '0);
  assign head_addr_o = addr_q[rd_ptr_q];
  assign head_data_o = data_q[rd_ptr_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        addr_q[i] <= '0;
        data_q[i] <= '0;
      end
    end else begin
      if (push_i) begin
        addr_q[wr_ptr_q] <= push_addr_i;
        data_q[wr_ptr_q] <= push_data_i;
        wr_ptr_q         <= ptr_inc(wr_ptr_q);
      end
      if (pop_i) rd_ptr_q <= ptr_inc(rd_ptr_q);
      if (push_i && !pop_i)      cnt_q <= cnt_q + 1'b1;
      else if (pop_i && !push_i) cnt_q <= cnt_q - 1'b1;
    end
  end

  // Scan oldest to youngest; the youngest match overrides.
  always_comb begin
    hit_o      = 1'b0;
    hit_data_o = '0;
    for (int k = DEPTH; k >= 1; k--) begin
      int idx;
      idx = (int'(wr_ptr_q) + DEPTH - k) % DEPTH;
      if (int'(cnt_q) >= k && addr_q[idx] == look_addr_i) begin
        hit_o      = 1'b1;
        hit_data_o = data_q[idx];
      end
    end
  end

  AST_NO_OVERFLOW:  assert property (@(posedge clk_i) disable iff (!rst_ni) push_i |-> !full_o); // R2
  AST_NO_UNDERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni) pop_i |-> !empty_o); // R4
endmodule

// File: rtl/sbuf_mem_ctl.sv
module sbuf_mem_ctl
  import sbuf_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rd_pend_i,
  input  logic [AW-1:0] rd_addr_i,
  input  logic          wq_avail_i,
  input  logic [AW-1:0] wq_addr_i,
  input  logic [DW-1:0] wq_data_i,
  output logic          mem_req_valid_o,
  output logic          mem_req_write_o,
  output logic [AW-1:0] mem_req_addr_o,
  output logic [DW-1:0] mem_req_wdata_o,
  input  logic          mem_req_ready_i,
  input  logic          mem_ack_i,
  input  logic [DW-1:0] mem_rdata_i,
  output logic          rd_issued_o,
  output logic          wr_done_o,
  output logic          rd_done_o,
  output logic [DW-1:0] rd_data_o
);
  logic     busy_q, busy_rd_q;
  mem_sel_e sel;
  logic     take;

  // Pending read wins the free port over queued writes.
  always_comb begin
    if (busy_q)          sel = SEL_IDLE;
    else if (rd_pend_i)  sel = SEL_RD;
    else if (wq_avail_i) sel = SEL_WR;
    else                 sel = SEL_IDLE;
  end

  assign mem_req_valid_o = (sel != SEL_IDLE);
  assign mem_req_write_o = (sel == SEL_WR);
  assign mem_req_addr_o  = (sel == SEL_RD) ? rd_addr_i : wq_addr_i;
  assign mem_req_wdata_o = wq_data_i;
  assign take            = mem_req_valid_o && mem_req_ready_i;
  assign rd_issued_o     = take && (sel == SEL_RD);
  assign wr_done_o       = busy_q && mem_ack_i && !busy_rd_q;
  assign rd_done_o       = busy_q && mem_ack_i && busy_rd_q;
  assign rd_data_o       = mem_rdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q    <= 1'b0;
      busy_rd_q <= 1'b0;
    end else if (take) begin
      busy_q    <= 1'b1;
      busy_rd_q <= (sel == SEL_RD);
    end else if (busy_q && mem_ack_i) begin
      busy_q    <= 1'b0;
    end
  end

  AST_ONE_INFLIGHT: assert property (@(posedge clk_i) disable iff (!rst_ni) busy_q |-> !mem_req_valid_o); // R3
  AST_RD_FIRST:     assert property (@(posedge clk_i) disable iff (!rst_ni)
                      (rd_pend_i && !busy_q) |-> (mem_req_valid_o && !mem_req_write_o)); // R5
endmodule

// File: rtl/store_bypass_buf.sv
module store_bypass_buf #(
  parameter int AW    = 8,
  parameter int DW    = 32,
  parameter int DEPTH = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  input  logic          req_write_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [DW-1:0] req_wdata_i,
  output logic          req_ready_o,
  output logic          rsp_valid_o,
  output logic [DW-1:0] rsp_rdata_o,
  output logic          mem_req_valid_o,
  output logic          mem_req_write_o,
  output logic [AW-1:0] mem_req_addr_o,
  output logic [DW-1:0] mem_req_wdata_o,
  input  logic          mem_req_ready_i,
  input  logic          mem_ack_i,
  input  logic [DW-1:0] mem_rdata_i,
  output logic          drained_o
);
  logic          full, empty, hit, pop;
  logic [AW-1:0] head_addr;
  logic [DW-1:0] head_data, hit_data, rd_data;
  logic          rd_issued, rd_done;
  logic          acc, wr_acc, rd_acc;
  logic          rd_busy_q, rd_pend_q, rsp_valid_q;
  logic [AW-1:0] rd_addr_q;
  logic [DW-1:0] rsp_data_q;

  assign req_ready_o = !rd_busy_q && !(req_write_i && full);
  assign acc         = req_valid_i && req_ready_o;
  assign wr_acc      = acc && req_write_i;
  assign rd_acc      = acc && !req_write_i;

  sbuf_fifo #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_fifo (
    .clk_i, .rst_ni,
    .push_i      (wr_acc),
    .push_addr_i (req_addr_i),
    .push_data_i (req_wdata_i),
    .pop_i       (pop),
    .look_addr_i (req_addr_i),
    .full_o      (full),
    .empty_o     (empty),
    .head_addr_o (head_addr),
    .head_data_o (head_data),
    .hit_o       (hit),
    .hit_data_o  (hit_data)
  );

  sbuf_mem_ctl #(.AW(AW), .DW(DW)) u_mem (
    .clk_i, .rst_ni,
    .rd_pend_i       (rd_pend_q),
    .rd_addr_i       (rd_addr_q),
    .wq_avail_i      (!empty),
    .wq_addr_i       (head_addr),
    .wq_data_i       (head_data),
    .mem_req_valid_o,
    .mem_req_write_o,
    .mem_req_addr_o,
    .mem_req_wdata_o,
    .mem_req_ready_i,
    .mem_ack_i,
    .mem_rdata_i,
    .rd_issued_o     (rd_issued),
    .wr_done_o       (pop),
    .rd_done_o       (rd_done),
    .rd_data_o       (rd_data)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_busy_q   <= 1'b0;
      rd_pend_q   <= 1'b0;
      rd_addr_q   <= '0;
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
    end else begin
      if (rd_acc)           rd_busy_q <= 1'b1;
      else if (rsp_valid_q) rd_busy_q <= 1'b0;
      if (rd_acc && !hit) begin
        rd_pend_q <= 1'b1;
        rd_addr_q <= req_addr_i;
      end else if (rd_issued) begin
        rd_pend_q <= 1'b0;
      end
      rsp_valid_q <= (rd_acc && hit) || rd_done;
      if (rd_acc && hit) rsp_data_q <= hit_data;
      else if (rd_done)  rsp_data_q <= rd_data;
    end
  end

  assign rsp_valid_o = rsp_valid_q;
  assign rsp_rdata_o = rsp_data_q;
  assign drained_o   = empty;

  AST_RSP_PULSE:  assert property (@(posedge clk_i) disable iff (!rst_ni) rsp_valid_o |=> !rsp_valid_o); // R6
  AST_READ_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni) rd_pend_q |-> !req_ready_o); // R8
  AST_DRAINED:    assert property (@(posedge clk_i) disable iff (!rst_ni)
                    drained_o |-> !(mem_req_valid_o && mem_req_write_o)); // R4
endmodule

// File: tb/sim_store_bypass_buf.sv
`timescale 1ns/1ps
module sim_store_bypass_buf;
  localparam int AW = 8, DW = 32, LAT = 6;

  logic          clk_i = 1'b0, rst_ni = 1'b0;
  logic          req_valid_i = 1'b0, req_write_i = 1'b0;
  logic [AW-1:0] req_addr_i = '0;
  logic [DW-1:0] req_wdata_i = '0;
  logic          req_ready_o, rsp_valid_o;
  logic [DW-1:0] rsp_rdata_o;
  logic          mem_req_valid_o, mem_req_write_o;
  logic [AW-1:0] mem_req_addr_o;
  logic [DW-1:0] mem_req_wdata_o;
  logic          mem_req_ready_i = 1'b1;
  logic          mem_ack_i;
  logic [DW-1:0] mem_rdata_i;
  logic          drained_o;

  store_bypass_buf #(.AW(AW), .DW(DW), .DEPTH(4)) u0 (.*);

  always #10 clk_i = ~clk_i;

  // Memory model: one transaction, ack after LAT cycles unless held.
  logic [DW-1:0] mem [256];
  logic          m_busy, m_wr, hold;
  logic [AW-1:0] m_addr;
  logic [DW-1:0] m_data;
  int            m_cnt, rd_cnt, log_n;
  logic [AW:0]   log_op [64];
  initial hold = 1'b0;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_busy <= 1'b0; mem_ack_i <= 1'b0; mem_rdata_i <= '0;
      m_wr <= 1'b0; m_addr <= '0; m_data <= '0; m_cnt <= 0;
      rd_cnt <= 0; log_n <= 0;
      for (int i = 0; i < 256; i++) mem[i] <= 32'h1000 + i;
    end else if (mem_ack_i) begin
      mem_ack_i <= 1'b0;
      m_busy    <= 1'b0;
      if (m_wr) mem[m_addr] <= m_data;
    end else if (m_busy) begin
      if (m_cnt != 0) m_cnt <= m_cnt - 1;
      else if (!hold) begin
        mem_ack_i   <= 1'b1;
        mem_rdata_i <= m_wr ? '0 : mem[m_addr];
      end
    end else if (mem_req_valid_o && mem_req_ready_i) begin
      m_busy <= 1'b1; m_cnt <= LAT;
      m_wr <= mem_req_write_o; m_addr <= mem_req_addr_o; m_data <= mem_req_wdata_o;
      if (log_n < 64) log_op[log_n] <= {mem_req_write_o, mem_req_addr_o};
      log_n <= log_n + 1;
      if (!mem_req_write_o) rd_cnt <= rd_cnt + 1;
    end
  end

  int n_chk = 0, n_fail = 0, proto_err = 0;
  bit done = 1'b0;

  // R3: a request while an earlier one is unacknowledged is a protocol error.
  always @(negedge clk_i) if (rst_ni && m_busy && mem_req_valid_o) proto_err++;

  task automatic chk(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk_i);
    req_valid_i = 1'b1; req_write_i = 1'b1; req_addr_i = a; req_wdata_i = d;
    while (!req_ready_o) @(negedge clk_i);
    @(posedge clk_i); #1 req_valid_i = 1'b0;
  endtask

  task automatic do_read(input logic [AW-1:0] a, output logic [DW-1:0] d, output int lat);
    @(negedge clk_i);
    req_valid_i = 1'b1; req_write_i = 1'b0; req_addr_i = a;
    while (!req_ready_o) @(negedge clk_i);
    @(posedge clk_i); #1 req_valid_i = 1'b0;
    lat = 1;
    @(negedge clk_i);
    while (!rsp_valid_o) begin @(negedge clk_i); lat++; end
    d = rsp_rdata_o;
  endtask

  // {write, addr, wdata, expected read data}
  localparam logic [72:0] VEC [12] = '{
    {1'b1, 8'h10, 32'hAAAA0001, 32'h0},
    {1'b1, 8'h11, 32'hBBBB0001, 32'h0},
    {1'b1, 8'h10, 32'hAAAA0002, 32'h0},
    {1'b0, 8'h10, 32'h0,        32'hAAAA0002},
    {1'b0, 8'h20, 32'h0,        32'h00001020},
    {1'b0, 8'h11, 32'h0,        32'hBBBB0001},
    {1'b1, 8'h30, 32'hCCCC0003, 32'h0},
    {1'b0, 8'h30, 32'h0,        32'hCCCC0003},
    {1'b0, 8'h10, 32'h0,        32'hAAAA0002},
    {1'b1, 8'h20, 32'hDDDD0004, 32'h0},
    {1'b0, 8'h20, 32'h0,        32'hDDDD0004},
    {1'b0, 8'h31, 32'h0,        32'h00001031}
  };

  initial begin
    logic [DW-1:0] d;
    int lat, base, rc0;
    bit prev_ack;
    #35 rst_ni = 1'b1;
    @(negedge clk_i);
    chk(req_ready_o && !rsp_valid_o && !mem_req_valid_o && drained_o, "R1",
        {28'h0, req_ready_o, rsp_valid_o, mem_req_valid_o, drained_o}, 32'h9);

    for (int i = 0; i < 12; i++) begin
      if (VEC[i][72]) do_write(VEC[i][71:64], VEC[i][63:32]);
      else begin
        do_read(VEC[i][71:64], d, lat);
        chk(d == VEC[i][31:0], "R9", d, VEC[i][31:0]);
      end
    end
    while (!drained_o) @(negedge clk_i);

    // Full queue with first write held in flight.
    hold = 1'b1;
    base = log_n;
    for (int i = 0; i < 4; i++) do_write(8'h40 + i, 32'h5000 + i);
    @(negedge clk_i);
    req_write_i = 1'b1;
    #1 chk(!req_ready_o, "R2", {31'h0, req_ready_o}, 32'h0);
    chk(!drained_o, "R4", {31'h0, drained_o}, 32'h0);
    rc0 = rd_cnt;
    do_read(8'h42, d, lat);
    chk(d == 32'h5002, "R6", d, 32'h5002);
    chk(lat == 1, "R6", lat, 1);
    chk(rd_cnt == rc0, "R6", rd_cnt, rc0);

    // Read miss overtakes the queued writes.
    @(negedge clk_i);
    req_valid_i = 1'b1; req_write_i = 1'b0; req_addr_i = 8'h60;
    while (!req_ready_o) @(negedge clk_i);
    @(posedge clk_i); #1 req_valid_i = 1'b0;
    repeat (3) begin
      @(negedge clk_i);
      chk(!req_ready_o, "R8", {31'h0, req_ready_o}, 32'h0);
    end
    hold = 1'b0;
    prev_ack = 1'b0;
    @(negedge clk_i);
    while (!rsp_valid_o) begin prev_ack = mem_ack_i; @(negedge clk_i); end
    chk(prev_ack, "R7", {31'h0, prev_ack}, 32'h1);
    chk(rsp_rdata_o == 32'h1060, "R7", rsp_rdata_o, 32'h1060);
    while (!drained_o) @(negedge clk_i);
    chk(drained_o && !mem_req_valid_o, "R4", {31'h0, mem_req_valid_o}, 32'h0);
    chk(log_op[base + 1] == {1'b0, 8'h60}, "R5", {23'h0, log_op[base + 1]}, {23'h0, 1'b0, 8'h60});
    for (int i = 0; i < 4; i++) begin
      int j;
      j = (i == 0) ? base : base + 1 + i;
      chk(log_op[j] == {1'b1, 8'h40 + 8'(i)}, "R3", {23'h0, log_op[j]}, {23'h0, 1'b1, 8'h40 + 8'(i)});
    end
    do_read(8'h43, d, lat);
    chk(d == 32'h5003, "R3", d, 32'h5003);
    chk(proto_err == 0, "R3", proto_err, 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog act=%h exp=%h", 32'h0, 32'h1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule